// File: doc/BRIEF.md
# DSI Video-Mode Line Packet Sequencer

This block decides which packet a DSI transmitter sends next when it runs in sync-pulse video mode. The block sizes each line from four horizontal word counts: sync width, back porch, active payload and front porch. It sizes each frame from four vertical line counts: sync lines, back-porch lines, active lines and front-porch lines. For every packet it presents one descriptor on a valid/ready handshake. The descriptor gives the packet kind, the DSI data type and the payload word count. Header ECC, CRC, lane striping and the physical layer all sit downstream of this block.

Each line is a fixed chain of six slots. The chain is a start-of-sync short packet, a sync-width blanking long packet, a sync-end short packet, a back-porch blanking long packet, the active slot and a front-porch blanking long packet. On vertical blanking lines the active slot carries blanking of the same length as the pixel payload, so every line in a frame takes the same number of bytes. On active lines the block raises a one-cycle pixel-request strobe when the pixel packet's descriptor is accepted, so the pixel source can start streaming. Timing inputs are copied into shadow registers only at a frame boundary.

Top module: `dsi_vid_pkt_seq`

## Requirements
- R1: While `rst_n` is low, and in the first clock cycle after its release, `desc_valid` and `pix_req` are 0. After that, `desc_valid` stays 1.
- R2: Each line is offered in the slot order sync-start short, sync-width long, sync-end short (data type 0x31), back-porch long, active long, front-porch long. Kind codes are 0 short, 1 blanking long, 2 pixel long.
- R3: Short packets carry word count 0. Each long packet carries its programmed word count. Blanking long packets use data type 0x19.
- R4: The active slot of a line in the active region is a pixel packet (kind 2) with data type `PIX_DT` (default 0x0B) and the active word count.
- R5: Every line in the vertical sync region starts with data type 0x01. All other lines start with data type 0x21.
- R6: On lines in the sync, back-porch and front-porch regions, the active slot is a blanking packet (kind 1, type 0x19) that carries the active word count.
- R7: A frame runs the regions in the order sync, back porch, active, front porch, each for its programmed number of lines. A region with a count of 0 is skipped, and frames repeat without gaps. At least one vertical count must be nonzero.
- R8: A zero sync-width, back-porch or front-porch word count drops that long packet from the line, and the next slot follows at once.
- R9: While `desc_valid` is 1 and `desc_ready` is 0, the descriptor fields hold, and no packet is skipped or repeated.
- R10: The timing inputs are captured only at reset release and when the last packet of a frame is accepted. A change in the middle of a frame first affects the following frame.
- R11: `pix_req` is 1 for exactly the cycles in which a pixel packet's descriptor is accepted.
- R12: The bytes of one line total 4 for each short packet plus word count + 6 for each long packet that is sent. This equals 14 + HACT plus (WC + 6) for each nonzero porch or sync-width count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hsa | input | WC_W | Sync-width blanking word count |
| cfg_hbp | input | WC_W | Back-porch blanking word count |
| cfg_hact | input | WC_W | Active payload word count (pixels × bits per pixel / 8) |
| cfg_hfp | input | WC_W | Front-porch blanking word count |
| cfg_vsa | input | LN_W | Vertical sync line count |
| cfg_vbp | input | LN_W | Vertical back-porch line count |
| cfg_vact | input | LN_W | Active line count |
| cfg_vfp | input | LN_W | Vertical front-porch line count |
| desc_valid | output | 1 | Descriptor present |
| desc_ready | input | 1 | Downstream accepts the descriptor |
| desc_kind | output | 2 | 0 short, 1 blanking long, 2 pixel long |
| desc_dt | output | 6 | DSI data type |
| desc_wc | output | WC_W | Payload word count (0 for short packets) |
| pix_req | output | 1 | Pixel packet accepted this cycle |

## Verification
All descriptor fields are decoded from registered slot and region state. The next descriptor is therefore on the outputs in the cycle right after the accepting edge, and `pix_req` is combinational in the same cycle as the handshake it reports. The bench drives `desc_ready` just after each falling edge and samples 1 ns later. The value it reads is the one the next rising edge acts upon. The first descriptor appears one cycle after reset release, and a captured timing change shows on the first packet after the accepting edge of a frame's last packet.

// File: rtl/dsi_seq_pkg.sv
package dsi_seq_pkg;
  // descriptor kinds
  localparam logic [1:0] PK_SHORT = 2'd0;
  localparam logic [1:0] PK_BLANK = 2'd1;
  localparam logic [1:0] PK_PIXEL = 2'd2;

  // vertical regions (index into count vector, order is behaviour)
  localparam logic [1:0] RG_VSA = 2'd0;
  localparam logic [1:0] RG_ACT = 2'd2;

  // DSI data types
  localparam logic [5:0] DT_VSS   = 6'h01;
  localparam logic [5:0] DT_HSS   = 6'h21;
  localparam logic [5:0] DT_HSE   = 6'h31;
  localparam logic [5:0] DT_BLANK = 6'h19;

  // line slots, in transmit order
  localparam logic [2:0] SL_SYNC = 3'd0;
  localparam logic [2:0] SL_HSA  = 3'd1;
  localparam logic [2:0] SL_END  = 3'd2;
  localparam logic [2:0] SL_HBP  = 3'd3;
  localparam logic [2:0] SL_ACT  = 3'd4;
  localparam logic [2:0] SL_HFP  = 3'd5;
  localparam logic [2:0] SL_WRAP = 3'd6;

  localparam int unsigned SHORT_BYTES = 4;
  localparam int unsigned LONG_OVH    = 6;

  function automatic logic [31:0] pkt_bytes(input logic [1:0] kind, input logic [31:0] wc);
    return (kind == PK_SHORT) ? 32'(SHORT_BYTES) : wc + 32'(LONG_OVH);
  endfunction

  function automatic logic [31:0] opt_long(input logic [31:0] wc);
    return (wc == 32'd0) ? 32'd0 : wc + 32'(LONG_OVH);
  endfunction

  function automatic logic [31:0] line_budget(input logic [31:0] hsa, input logic [31:0] hbp,
                                              input logic [31:0] hact, input logic [31:0] hfp);
    return 32'(2 * SHORT_BYTES) + hact + 32'(LONG_OVH) + opt_long(hsa) + opt_long(hbp) + opt_long(hfp);
  endfunction
endpackage

// File: rtl/dsi_line_slots.sv
module dsi_line_slots
  import dsi_seq_pkg::*;
#(
  parameter int WC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [WC_W-1:0] wc_hsa,
  input  logic [WC_W-1:0] wc_hbp,
  input  logic [WC_W-1:0] wc_hfp,
  output logic [2:0]      slot,
  output logic            line_done
);
  // next slot, skipping optional long packets whose count is zero
  function automatic logic [2:0] nxt_slot(input logic [2:0] cur, input logic hsa_on,
                                          input logic hbp_on, input logic hfp_on);
    case (cur)
      SL_SYNC: return hsa_on ? SL_HSA : SL_END;
      SL_HSA:  return SL_END;
      SL_END:  return hbp_on ? SL_HBP : SL_ACT;
      SL_HBP:  return SL_ACT;
      SL_ACT:  return hfp_on ? SL_HFP : SL_WRAP;
      default: return SL_WRAP;
    endcase
  endfunction

  logic [2:0] slot_nxt;

  assign slot_nxt  = nxt_slot(slot, wc_hsa != '0, wc_hbp != '0, wc_hfp != '0);
  assign line_done = adv && (slot_nxt == SL_WRAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         slot <= SL_SYNC;
    else if (line_done) slot <= SL_SYNC;
    else if (adv)       slot <= slot_nxt;
  end

  // R9: slot moves only on an accepted descriptor
  a_r9_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(slot));
endmodule

// File: rtl/dsi_vert_ctr.sv
module dsi_vert_ctr
  import dsi_seq_pkg::*;
#(
  parameter int LN_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_done,
  input  logic                 load,
  input  logic [3:0][LN_W-1:0] cnt_cur,
  input  logic [3:0][LN_W-1:0] cnt_new,
  output logic [1:0]           region,
  output logic                 frame_end
);
  function automatic logic [1:0] first_reg(input logic [3:0][LN_W-1:0] c);
    logic [1:0] r;
    r = RG_VSA;
    for (int s = 3; s >= 0; s--) if (c[s] != '0) r = 2'(s);
    return r;
  endfunction

  function automatic logic [1:0] nxt_reg(input logic [1:0] cur, input logic [3:0][LN_W-1:0] c);
    logic [1:0] r;
    logic [1:0] cand;
    r = cur;
    for (int s = 3; s >= 1; s--) begin
      cand = cur + 2'(s);
      if (c[cand] != '0) r = cand;
    end
    return r;
  endfunction

  logic [LN_W-1:0] line_idx;
  logic [1:0]      reg_nxt;
  logic            last_line;

  assign reg_nxt   = nxt_reg(region, cnt_cur);
  assign last_line = (line_idx + LN_W'(1)) == cnt_cur[region];
  assign frame_end = line_done && last_line && (reg_nxt <= region);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region   <= RG_VSA;
      line_idx <= '0;
    end else if (load) begin
      region   <= first_reg(cnt_new);
      line_idx <= '0;
    end else if (line_done) begin
      if (last_line) begin
        region   <= reg_nxt;
        line_idx <= '0;
      end else begin
        line_idx <= line_idx + LN_W'(1);
      end
    end
  end

  // R7: line index never runs past the programmed count of its region
  a_r7_line_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_cur[region] != '0) |-> (line_idx < cnt_cur[region]));
endmodule

// File: rtl/dsi_vid_pkt_seq.sv
module dsi_vid_pkt_seq
  import dsi_seq_pkg::*;
#(
  parameter int          WC_W   = 16,
  parameter int          LN_W   = 12,
  parameter logic [5:0]  PIX_DT = 6'h0B
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WC_W-1:0] cfg_hsa,
  input  logic [WC_W-1:0] cfg_hbp,
  input  logic [WC_W-1:0] cfg_hact,
  input  logic [WC_W-1:0] cfg_hfp,
  input  logic [LN_W-1:0] cfg_vsa,
  input  logic [LN_W-1:0] cfg_vbp,
  input  logic [LN_W-1:0] cfg_vact,
  input  logic [LN_W-1:0] cfg_vfp,
  output logic            desc_valid,
  input  logic            desc_ready,
  output logic [1:0]      desc_kind,
  output logic [5:0]      desc_dt,
  output logic [WC_W-1:0] desc_wc,
  output logic            pix_req
);
  localparam int SUM_W = WC_W + 3;

  logic [WC_W-1:0] sh_hsa, sh_hbp, sh_hact, sh_hfp;
  logic [LN_W-1:0] sh_vsa, sh_vbp, sh_vact, sh_vfp;
  logic            ld_pend;
  logic            hs;
  logic            line_done;
  logic            frame_end;
  logic            frame_reload;
  logic [2:0]      slot;
  logic [1:0]      region;
  logic            in_act;
  logic [SUM_W-1:0] line_bytes;
  logic [3:0][LN_W-1:0] cnt_cur, cnt_new;

  assign desc_valid   = !ld_pend;
  assign hs           = desc_valid && desc_ready;
  assign frame_reload = ld_pend || frame_end;
  assign in_act       = (region == RG_ACT);
  assign pix_req      = hs && (desc_kind == PK_PIXEL);
  assign cnt_cur      = {sh_vfp, sh_vact, sh_vbp, sh_vsa};
  assign cnt_new      = {cfg_vfp, cfg_vact, cfg_vbp, cfg_vsa};

  // shadow timing, captured only at frame boundaries
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_pend <= 1'b1;
      {sh_hsa, sh_hbp, sh_hact, sh_hfp} <= '0;
      {sh_vsa, sh_vbp, sh_vact, sh_vfp} <= '0;
    end else if (frame_reload) begin
      ld_pend <= 1'b0;
      {sh_hsa, sh_hbp, sh_hact, sh_hfp} <= {cfg_hsa, cfg_hbp, cfg_hact, cfg_hfp};
      {sh_vsa, sh_vbp, sh_vact, sh_vfp} <= {cfg_vsa, cfg_vbp, cfg_vact, cfg_vfp};
    end
  end

  dsi_line_slots #(.WC_W(WC_W)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (hs),
    .wc_hsa    (sh_hsa),
    .wc_hbp    (sh_hbp),
    .wc_hfp    (sh_hfp),
    .slot      (slot),
    .line_done (line_done)
  );

  dsi_vert_ctr #(.LN_W(LN_W)) u_vert (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_done (line_done),
    .load      (frame_reload),
    .cnt_cur   (cnt_cur),
    .cnt_new   (cnt_new),
    .region    (region),
    .frame_end (frame_end)
  );

  // descriptor decode from slot and region
  always_comb begin
    desc_kind = PK_SHORT;
    desc_dt   = (region == RG_VSA) ? DT_VSS : DT_HSS;
    desc_wc   = '0;
    case (slot)
      SL_HSA: begin desc_kind = PK_BLANK; desc_dt = DT_BLANK; desc_wc = sh_hsa; end
      SL_END: desc_dt = DT_HSE;
      SL_HBP: begin desc_kind = PK_BLANK; desc_dt = DT_BLANK; desc_wc = sh_hbp; end
      SL_ACT: begin
        desc_kind = in_act ? PK_PIXEL : PK_BLANK;
        desc_dt   = in_act ? PIX_DT : DT_BLANK;
        desc_wc   = sh_hact;
      end
      SL_HFP: begin desc_kind = PK_BLANK; desc_dt = DT_BLANK; desc_wc = sh_hfp; end
      default: ;
    endcase
  end

  // running byte count of the current line
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         line_bytes <= '0;
    else if (line_done) line_bytes <= '0;
    else if (hs)        line_bytes <= line_bytes + SUM_W'(pkt_bytes(desc_kind, 32'(desc_wc)));
  end

  // R9: descriptor holds under back-pressure
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_kind) && $stable(desc_dt) && $stable(desc_wc)));

  // R12: accepted bytes of a line match the budget of the shadow timing
  a_r12_budget: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> ((32'(line_bytes) + pkt_bytes(desc_kind, 32'(desc_wc)))
                   == line_budget(32'(sh_hsa), 32'(sh_hbp), 32'(sh_hact), 32'(sh_hfp))));

  // R2: a new line always opens with a start-of-sync short packet
  a_r2_line_open: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> (desc_kind == PK_SHORT && desc_dt != DT_HSE && desc_wc == '0));

  // R8: no optional blanking packet goes out empty
  a_r8_no_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_kind == PK_BLANK && slot != SL_ACT) |-> (desc_wc != '0));

  // R10: shadow timing only moves while a line is at its first slot
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != SL_SYNC) |-> ($stable(sh_hact) && $stable(sh_hsa) && $stable(sh_hbp) && $stable(sh_hfp)
                           && $stable(sh_vsa) && $stable(sh_vbp) && $stable(sh_vact) && $stable(sh_vfp)));
endmodule

// File: tb/dsi_vid_pkt_seq_tb.sv
module dsi_vid_pkt_seq_tb;
  localparam int WC_W = 16;
  localparam int LN_W = 12;
  localparam logic [5:0] PIX = 6'h0B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [WC_W-1:0] cfg_hsa, cfg_hbp, cfg_hact, cfg_hfp;
  logic [LN_W-1:0] cfg_vsa, cfg_vbp, cfg_vact, cfg_vfp;
  logic desc_valid, desc_ready, pix_req;
  logic [1:0] desc_kind;
  logic [5:0] desc_dt;
  logic [WC_W-1:0] desc_wc;

  always #2 clk = ~clk;

  dsi_vid_pkt_seq #(.WC_W(WC_W), .LN_W(LN_W), .PIX_DT(PIX)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_hsa(cfg_hsa), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hfp(cfg_hfp),
    .cfg_vsa(cfg_vsa), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
    .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_kind(desc_kind),
    .desc_dt(desc_dt), .desc_wc(desc_wc), .pix_req(pix_req)
  );

  int errs = 0;
  int checks = 0;
  bit abort = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit have_hold = 0;
  logic [1:0] h_kind;
  logic [5:0] h_dt;
  logic [WC_W-1:0] h_wc;
  int line_obs;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int hsa, input int hbp, input int hact, input int hfp,
                         input int vsa, input int vbp, input int vact, input int vfp);
    cfg_hsa = WC_W'(hsa); cfg_hbp = WC_W'(hbp); cfg_hact = WC_W'(hact); cfg_hfp = WC_W'(hfp);
    cfg_vsa = LN_W'(vsa); cfg_vbp = LN_W'(vbp); cfg_vact = LN_W'(vact); cfg_vfp = LN_W'(vfp);
  endtask

  // wait for the next accepted descriptor and compare it
  task automatic expect_pkt(input int k, input int dt, input int wc, input string req);
    int waits = 0;
    bit got = 0;
    while (!got && !abort) begin
      @(negedge clk);
      desc_ready = lfsr[0] | lfsr[3];
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      if (have_hold) begin // R9
        chk(desc_valid && desc_kind == h_kind && desc_dt == h_dt && desc_wc == h_wc,
            "R9", "held descriptor wc", int'(desc_wc), int'(h_wc));
        have_hold = 0;
      end
      if (desc_valid && desc_ready) begin
        chk(int'(desc_kind) == k, req, "kind", int'(desc_kind), k);
        chk(int'(desc_dt) == dt, req, "data type", int'(desc_dt), dt);
        chk(int'(desc_wc) == wc, req, "word count", int'(desc_wc), wc);
        chk(pix_req == (k == 2), "R11", "pix_req on accept", int'(pix_req), int'(k == 2));
        line_obs += (desc_kind == 2'd0) ? 4 : int'(desc_wc) + 6;
        got = 1;
      end else begin
        chk(pix_req == 1'b0, "R11", "pix_req idle", int'(pix_req), 0);
        if (desc_valid) begin
          have_hold = 1; h_kind = desc_kind; h_dt = desc_dt; h_wc = desc_wc;
        end
      end
      waits++;
      if (waits > 60 && !got) begin
        chk(1'b0, req, "descriptor never accepted", 0, 1);
        abort = 1;
      end
    end
  endtask

  task automatic run_frame(input int f);
    int s_hsa = int'(cfg_hsa), s_hbp = int'(cfg_hbp), s_hact = int'(cfg_hact), s_hfp = int'(cfg_hfp);
    int cnt [4];
    cnt[0] = int'(cfg_vsa); cnt[1] = int'(cfg_vbp); cnt[2] = int'(cfg_vact); cnt[3] = int'(cfg_vfp);
    for (int rg = 0; rg < 4; rg++) begin
      for (int ln = 0; ln < cnt[rg]; ln++) begin
        // R10: timing changed mid-frame must wait for the next frame
        if (f == 1 && rg == 2 && ln == 1) set_cfg(0, 7, 4, 0, 2, 0, 2, 2);
        if (f == 3 && rg == 2 && ln == 0) set_cfg(1, 0, 3, 1, 1, 1, 1, 0);
        line_obs = 0;
        expect_pkt(0, (rg == 0) ? 8'h01 : 8'h21, 0, (rg == 0) ? "R5" : "R7");
        if (s_hsa != 0) expect_pkt(1, 8'h19, s_hsa, "R3");
        expect_pkt(0, 8'h31, 0, "R2");
        if (s_hbp != 0) expect_pkt(1, 8'h19, s_hbp, "R8");
        if (rg == 2) expect_pkt(2, int'(PIX), s_hact, "R4");
        else         expect_pkt(1, 8'h19, s_hact, "R6");
        if (s_hfp != 0) expect_pkt(1, 8'h19, s_hfp, "R10");
        if (!abort)
          chk(line_obs == 14 + s_hact + (s_hsa ? s_hsa + 6 : 0) + (s_hbp ? s_hbp + 6 : 0)
                          + (s_hfp ? s_hfp + 6 : 0),
              "R12", "line bytes", line_obs,
              14 + s_hact + (s_hsa ? s_hsa + 6 : 0) + (s_hbp ? s_hbp + 6 : 0) + (s_hfp ? s_hfp + 6 : 0));
      end
    end
  endtask

  initial begin
    desc_ready = 1'b0;
    set_cfg(3, 2, 5, 4, 1, 2, 3, 1);
    repeat (3) @(negedge clk);
    #1;
    chk(desc_valid == 1'b0, "R1", "valid in reset", int'(desc_valid), 0);
    chk(pix_req == 1'b0, "R1", "pix_req in reset", int'(pix_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(desc_valid == 1'b0, "R1", "valid first cycle", int'(desc_valid), 0);
    // frames 0,1: set A; 2,3: set B (zero porch/sync, skipped region); 4: set C
    for (int f = 0; f < 5; f++) if (!abort) run_frame(f);
    @(negedge clk); #1;
    chk(desc_valid == 1'b1, "R1", "valid stays high", int'(desc_valid), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule